// File: doc/BRIEF.md
# Edge-Masked Interrupt Latch Controller

This block watches eight asynchronous status lines coming from a USB on-the-go transceiver's analog front end. The lines are bus-voltage valid, session valid, D+ high, ID grounded, D- high, ID floating, automatic-connect event and car-kit interrupt. Each line first passes through a two-stage synchroniser. A rising or falling transition of the synchronised value sets a sticky pending bit when the matching per-bit edge enable allows it. Software reads the live synchronised state, the pending bits and the two enable masks through a small register port. It changes the pending bits and the masks by writing ones to a set address or to a clear address.

Any pending bit drives an active-low interrupt request. The request is presented both as a level and as a pull-down enable for an open-drain pad. While the device is suspended and the alternate routing is enabled, the same request also appears on a second active-low pin. In suspend, the automatic-connect event (bit 6) cannot latch from hardware. All other sources keep working in suspend.

Top module: `irq_edge_latch`

## Requirements
- R1: After reset, the pending bits and both edge masks read 0, `irq_n` and `alt_irq_n` are 1, and `irq_pull` is 0.
- R2: Reading address 0 returns the synchronised status with bit 0 bus-valid, bit 1 session-valid, bit 2 D+ high, bit 3 ID grounded, bit 4 D- high, bit 5 ID floating, bit 6 auto-connect event, bit 7 car-kit interrupt. Reading it does not change any register. A status change shows there after two clock edges.
- R3: A 0-to-1 transition of a synchronised bit whose rising mask bit is 1 sets the pending bit. The pending bit becomes readable on the third rising clock edge after the input changes.
- R4: A 1-to-0 transition of a synchronised bit whose falling mask bit is 1 sets the pending bit.
- R5: A transition whose direction is not enabled in the masks leaves the pending bit unchanged.
- R6: The register addresses are: pending set 2, pending clear 3, rising mask set 4, rising mask clear 5, falling mask set 6, falling mask clear 7. A write of ones to a set address sets those bits, and a write of ones to a clear address clears them. Zero bits in the write data leave bits unchanged. Both addresses of a pair read back the same register.
- R7: `irq_n` is 0 and `irq_pull` is 1 whenever any pending bit is 1. They return to 1 and 0 only when all pending bits are clear.
- R8: `alt_irq_n` follows `irq_n` while `suspend` and `alt_irq_en` are both 1. Otherwise `alt_irq_n` is 1.
- R9: While `suspend` is 1, edges on bit 6 do not set its pending bit. Other bits still latch.
- R10: If a hardware edge and a clear write hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_in | input | 8 | Asynchronous status lines |
| suspend | input | 1 | Power-down state |
| alt_irq_en | input | 1 | Route the request to the alternate pin during suspend |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data, ones select bits |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq_n | output | 1 | Active-low interrupt level |
| irq_pull | output | 1 | Open-drain pull-down enable for the interrupt pad |
| alt_irq_n | output | 1 | Alternate active-low interrupt pin |

## Verification
On every cycle, the assertions check the following properties:
- A pending request stays asserted until a clear write arrives.
- An enabled synchronised edge always produces a pending bit.
- A pending bit never rises without an enabled edge or a set write.
- The alternate pin stays quiet outside suspend with routing enabled.
- Bit 6 stays clear during suspend unless software forces it.

Only the bench's scenarios can show the following behaviours:
- The end-to-end latency through the synchroniser.
- The bit order seen at the read port.
- The side-effect-free status read.
- The readback of both set and clear addresses.
- Which side wins when a hardware edge and a clear write meet in one cycle.

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int GATED_BIT   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_in,
  input  logic               suspend,
  input  logic               alt_irq_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [NUM_SRC-1:0] rd_data,
  output logic               irq_n,
  output logic               irq_pull,
  output logic               alt_irq_n
);
  localparam logic [ADDR_W-1:0] A_SRC    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LAT_S  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LAT_C  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RISE_S = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RISE_C = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FALL_S = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_FALL_C = ADDR_W'(7);

  logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] cur, prev;
  logic [NUM_SRC-1:0] rise_mask, fall_mask, pend;
  logic [NUM_SRC-1:0] gate, hw_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= status_in;

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= '0;
        else        sync_q[g] <= sync_q[g-1];
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= cur;

  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_gate
      if (g == GATED_BIT) begin : g_off
        assign gate[g] = ~suspend;
      end else begin : g_on
        assign gate[g] = 1'b1;
      end
    end
  endgenerate

  assign hw_set = gate & ((cur & ~prev & rise_mask) | (~cur & prev & fall_mask));

  wire wr_ls = wr_en && wr_addr == A_LAT_S;
  wire wr_lc = wr_en && wr_addr == A_LAT_C;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else pend <= ((pend | (wr_ls ? wr_data : '0)) & ~(wr_lc ? wr_data : '0)) | hw_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rise_mask <= '0;
    else if (wr_en && wr_addr == A_RISE_S) rise_mask <= rise_mask | wr_data;
    else if (wr_en && wr_addr == A_RISE_C) rise_mask <= rise_mask & ~wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fall_mask <= '0;
    else if (wr_en && wr_addr == A_FALL_S) fall_mask <= fall_mask | wr_data;
    else if (wr_en && wr_addr == A_FALL_C) fall_mask <= fall_mask & ~wr_data;

  always_comb
    case (rd_addr)
      A_SRC:             rd_data = cur;
      A_LAT_S, A_LAT_C:   rd_data = pend;
      A_RISE_S, A_RISE_C: rd_data = rise_mask;
      A_FALL_S, A_FALL_C: rd_data = fall_mask;
      default:           rd_data = '0;
    endcase

  assign irq_n     = ~|pend;
  assign irq_pull  = |pend;
  assign alt_irq_n = (suspend && alt_irq_en) ? irq_n : 1'b1;
endmodule

module irq_edge_latch_chk #(
  parameter int NUM_SRC   = 8,
  parameter int ADDR_W    = 3,
  parameter int GATED_BIT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] cur,
  input logic [NUM_SRC-1:0] prev,
  input logic [NUM_SRC-1:0] rise_mask,
  input logic [NUM_SRC-1:0] fall_mask,
  input logic [NUM_SRC-1:0] pend,
  input logic               suspend,
  input logic               alt_irq_en,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [NUM_SRC-1:0] wr_data,
  input logic               irq_n,
  input logic               alt_irq_n
);
  wire clr_wr = wr_en && wr_addr == ADDR_W'(3);
  wire set_wr = wr_en && wr_addr == ADDR_W'(2);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !clr_wr) |=> !irq_n);

  assert_alt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(suspend && alt_irq_en) |-> alt_irq_n);

  assert_alt_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && alt_irq_en) |-> (alt_irq_n == irq_n));

  assert_gated_in_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && !pend[GATED_BIT] && !(set_wr && wr_data[GATED_BIT])) |=> !pend[GATED_BIT]);

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      assert_rise_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[i] && !prev[i] && rise_mask[i] && (i != GATED_BIT || !suspend)) |=> pend[i]);
      assert_fall_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur[i] && prev[i] && fall_mask[i] && (i != GATED_BIT || !suspend)) |=> pend[i]);
      assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[i] && !(set_wr && wr_data[i]) && !(cur[i] && !prev[i] && rise_mask[i])
         && !(!cur[i] && prev[i] && fall_mask[i])) |=> !pend[i]);
    end
  endgenerate
endmodule

bind irq_edge_latch irq_edge_latch_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .GATED_BIT(GATED_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .rise_mask(rise_mask),
  .fall_mask(fall_mask), .pend(pend), .suspend(suspend), .alt_irq_en(alt_irq_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n), .alt_irq_n(alt_irq_n)
);

// File: tb/tb_irq_edge_latch.sv
module tb_irq_edge_latch;
  logic       clk = 0, rst_n = 0;
  logic [7:0] status_in = '0;
  logic       suspend = 0, alt_irq_en = 0, wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n, irq_pull, alt_irq_n;

  irq_edge_latch dut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] data;
    logic       irq;
    logic       alt;
    string      tag;
  } item_t;

  item_t q[$];
  int runs = 0, fails = 0;
  bit done = 0;

  initial begin : monitor
    item_t it;
    forever begin
      wait (q.size() != 0);
      #1;
      it = q[0];
      runs++;
      if (rd_data !== it.data || irq_n !== it.irq || irq_pull !== ~it.irq || alt_irq_n !== it.alt) begin
        fails++;
        $display("FAIL %s: got data=%h irq_n=%b pull=%b alt=%b, expected data=%h irq_n=%b pull=%b alt=%b",
                 it.tag, rd_data, irq_n, irq_pull, alt_irq_n, it.data, it.irq, ~it.irq, it.alt);
      end
      void'(q.pop_front());
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] d, input logic irq,
                           input logic alt, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.data = d; it.irq = irq; it.alt = alt; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drive_src(input logic [7:0] v);
    @(negedge clk);
    status_in = v;
    repeat (2) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin : watchdog
    #(20 * 20000);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    expect_rd(3'd2, 8'h00, 1, 1, "R1 pending");
    expect_rd(3'd4, 8'h00, 1, 1, "R1 rise mask");
    expect_rd(3'd6, 8'h00, 1, 1, "R1 fall mask");
    // R6 mask set/clear and readback on both addresses
    wr(3'd4, 8'h0D);
    wr(3'd5, 8'h08);
    expect_rd(3'd4, 8'h05, 1, 1, "R6 rise set addr");
    expect_rd(3'd5, 8'h05, 1, 1, "R6 rise clear addr");
    // R3 rising edge latches; R2 source read and latency
    drive_src(8'h01);
    expect_rd(3'd0, 8'h01, 0, 1, "R2 source bit0");
    expect_rd(3'd0, 8'h01, 0, 1, "R2 source reread no side effect");
    expect_rd(3'd3, 8'h01, 0, 1, "R3 rise latch");
    // R5 unmasked rising edge
    drive_src(8'h03);
    expect_rd(3'd2, 8'h01, 0, 1, "R5 unmasked rise");
    // R7 clear drops request
    wr(3'd3, 8'h01);
    expect_rd(3'd2, 8'h00, 1, 1, "R7 cleared");
    // R4 falling edge
    wr(3'd6, 8'h02);
    drive_src(8'h01);
    expect_rd(3'd2, 8'h02, 0, 1, "R4 fall latch");
    drive_src(8'h00);
    expect_rd(3'd2, 8'h02, 0, 1, "R5 unmasked fall");
    wr(3'd3, 8'hFF);
    // R6 force via set address, zeros leave others
    wr(3'd2, 8'h80);
    expect_rd(3'd2, 8'h80, 0, 1, "R6 forced set");
    wr(3'd3, 8'h00);
    expect_rd(3'd2, 8'h80, 0, 1, "R6 zero clear no effect");
    wr(3'd3, 8'h80);
    expect_rd(3'd2, 8'h00, 1, 1, "R7 idle");
    // R9 gated bit during suspend, R8 alternate routing
    wr(3'd4, 8'h40);
    @(negedge clk); suspend = 1; alt_irq_en = 1;
    drive_src(8'h40);
    expect_rd(3'd2, 8'h00, 1, 1, "R9 auto-connect ignored in suspend");
    drive_src(8'h44);
    expect_rd(3'd2, 8'h04, 0, 0, "R8 alt pin follows in suspend");
    @(negedge clk); alt_irq_en = 0;
    expect_rd(3'd2, 8'h04, 0, 1, "R8 alt pin quiet when disabled");
    @(negedge clk); suspend = 0;
    wr(3'd3, 8'h04);
    expect_rd(3'd2, 8'h00, 1, 1, "R8 cleared");
    // R10 edge and clear in the same cycle
    wr(3'd4, 8'h08);
    @(negedge clk); status_in = 8'h4C;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'd3; wr_data = 8'h08;
    @(negedge clk); wr_en = 0;
    expect_rd(3'd2, 8'h08, 0, 1, "R10 set wins over clear");
    expect_rd(3'd0, 8'h4C, 0, 1, "R2 source order");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule